// File: doc/BRIEF.md
# Cache Flush and Maintenance Controller

This block looks after the per-line state of a small write-back data cache of 4 KB with 32-byte lines, which gives 128 lines. It keeps one valid bit and one dirty bit for each line. The cache datapath sets these bits through mark ports and reads them back through a probe port. Software reaches the controller through a byte-wide register interface with two registers: a line-count register and a control register. The control register holds a cache-off bit, a flush start/busy bit, the bulk-clear enables and the force-set-all controls.

A flush walks the lines in ascending order from line 0 and checks each one. It takes one cycle per line that needs no write-back. For a line that is both valid and dirty it raises a write-back request that names the line, then stalls on that line until the write-back acknowledge arrives. When the walk ends, the busy bit drops. At the same clock edge the valid and/or dirty arrays are wiped, as the flush-clear enables select. Writing the control register with the cache-off bit set wipes the arrays as the turn-off enables select.

Top module: `cache_maint_ctrl`

## Requirements
- R1: After reset, the line-count register (address 0) reads 0x7F and the control register (address 1) reads 0xF0. Every valid and dirty bit is 0 and no write-back is requested.
- R2: The state holds 128 lines. A pulse on `fill_en` sets the valid bit of `fill_idx`, and a pulse on `dirty_en` sets the dirty bit of `dirty_idx`. From the next cycle, `probe_valid`/`probe_dirty` show the bits of line `probe_idx`.
- R3: With a line count N of 1 to 127, a flush checks lines 0 to N in ascending order and never goes past line N. With a count of 0 it checks no line and ends one cycle after it starts.
- R4: Control bit 0 is the flush bit. Writing it as 1 starts a flush, and from the next cycle the bit reads 1 until the flush ends, when it returns to 0 by itself. Writing it while busy has no further effect.
- R5: A write of the flush bit as 1 is ignored when the cache-off bit (control bit 1) is already 1 or is being written as 1 in the same write.
- R6: A write-back is requested only for a checked line that is both valid and dirty, with `wb_line` naming it. Other checked lines are passed over at one per cycle.
- R7: `wb_req` stays high with `wb_line` unchanged until `wb_ack` is sampled high. Each acknowledge completes exactly one line.
- R8: At the edge where a flush ends, all valid bits are cleared if control bit 4 is 1, and all dirty bits are cleared if control bit 5 is 1.
- R9: A write to the control register with bit 1 set clears all valid bits if the written bit 6 is 1, and all dirty bits if the written bit 7 is 1.
- R10: While control bit 2 is 1, every valid bit is forced to 1. While bit 3 is 1, every dirty bit is forced to 1. This forcing takes priority over every clear and mark.
- R11: Writes to the line-count register while a flush is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 line count, 1 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| fill_en | input | 1 | Set the valid bit of `fill_idx` |
| fill_idx | input | 7 | Line to mark valid |
| dirty_en | input | 1 | Set the dirty bit of `dirty_idx` |
| dirty_idx | input | 7 | Line to mark dirty |
| probe_idx | input | 7 | Line whose state bits are shown |
| probe_valid | output | 1 | Valid bit of `probe_idx` |
| probe_dirty | output | 1 | Dirty bit of `probe_idx` |
| wb_req | output | 1 | Write-back request for `wb_line` |
| wb_line | output | 7 | Line being checked or written back |
| wb_ack | input | 1 | Write-back done handshake |

## Verification
The hardest case to reach from the ports is a flush that runs across all 128 lines with every line needing a write-back. Marking lines one at a time would take hundreds of cycles. The stimulus instead uses the force-set-all controls to make every line valid and dirty in one cycle, then releases them and runs a full-length flush, with the acknowledge returned immediately. Shorter flushes use sparse dirty patterns, including dirty-but-invalid lines and a dirty line just past the last checked line. In those runs the acknowledge is held off for several cycles, and the line count is rewritten while the walk is still running.

// File: rtl/cmaint_pkg.sv
// Package: shared constants and types of the cache maintenance controller.
// Assumes a 4 KB cache with 32-byte lines, so 128 lines and 7-bit line indices.
package cmaint_pkg;

    localparam int CACHE_BYTES = 4096;
    localparam int LINE_BYTES  = 32;
    localparam int NUM_LINES   = CACHE_BYTES / LINE_BYTES;
    localparam int LINE_IDX_W  = $clog2(NUM_LINES);

    // register selects
    localparam logic REG_COUNT = 1'b0;
    localparam logic REG_CTRL  = 1'b1;

    // control register bit positions
    localparam int CB_FLUSH   = 0;
    localparam int CB_OFF     = 1;
    localparam int CB_SET_V   = 2;
    localparam int CB_SET_D   = 3;
    localparam int CB_FCLR_V  = 4;
    localparam int CB_FCLR_D  = 5;
    localparam int CB_OCLR_V  = 6;
    localparam int CB_OCLR_D  = 7;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_SCAN,
        WK_WAIT
    } walk_state_t;

endpackage

// File: rtl/cmaint_line_bits.sv
// Module: one per-line state bit array (used for valid and for dirty).
// Assumes single-line mark pulses from the datapath. Priority is
// force-set-all over bulk clear over the single-line mark.
module cmaint_line_bits #(
    parameter int LINES = 128,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mark_en_i,
    input  logic [IDX_W-1:0] mark_idx_i,
    input  logic             clr_all_i,
    input  logic             set_all_i,
    output logic [LINES-1:0] bits_o
);

    logic [LINES-1:0] bits_q;

    // Update the array: reset, force-set, bulk clear, or set one line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (set_all_i) begin
            bits_q <= '1;
        end else if (clr_all_i) begin
            bits_q <= '0;
        end else if (mark_en_i) begin
            bits_q[mark_idx_i] <= 1'b1;
        end
    end

    assign bits_o = bits_q;

    AST_SET_ALL_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(set_all_i) |-> (&bits_o)); // R10

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_all_i) && !$past(set_all_i)) |-> (bits_o == '0)); // R8

endmodule

// File: rtl/cmaint_regs.sv
// Module: byte-wide register file holding the line count and control bits.
// Assumes one register access per cycle and a combinational read path.
// Produces the flush start and turn-off clear pulses from write decodes.
module cmaint_regs #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             addr_i,
    input  logic [7:0]       wdata_i,
    output logic [7:0]       rdata_o,
    input  logic             busy_i,
    output logic [IDX_W-1:0] count_o,
    output logic             start_o,
    output logic             set_v_o,
    output logic             set_d_o,
    output logic             fclr_v_o,
    output logic             fclr_d_o,
    output logic             off_clr_v_o,
    output logic             off_clr_d_o
);
    import cmaint_pkg::*;

    logic [IDX_W-1:0] count_q;
    logic             off_q, set_v_q, set_d_q;
    logic             fclr_v_q, fclr_d_q, oclr_v_q, oclr_d_q;
    logic             ctrl_wr, count_wr;

    assign ctrl_wr  = wr_i && (addr_i == REG_CTRL);
    assign count_wr = wr_i && (addr_i == REG_COUNT) && !busy_i;

    // Line count register: all ones after reset, frozen while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '1;
        end else if (count_wr) begin
            count_q <= wdata_i[IDX_W-1:0];
        end
    end

    // Control register fields other than the self-clearing flush bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q    <= 1'b0;
            set_v_q  <= 1'b0;
            set_d_q  <= 1'b0;
            fclr_v_q <= 1'b1;
            fclr_d_q <= 1'b1;
            oclr_v_q <= 1'b1;
            oclr_d_q <= 1'b1;
        end else if (ctrl_wr) begin
            off_q    <= wdata_i[CB_OFF];
            set_v_q  <= wdata_i[CB_SET_V];
            set_d_q  <= wdata_i[CB_SET_D];
            fclr_v_q <= wdata_i[CB_FCLR_V];
            fclr_d_q <= wdata_i[CB_FCLR_D];
            oclr_v_q <= wdata_i[CB_OCLR_V];
            oclr_d_q <= wdata_i[CB_OCLR_D];
        end
    end

    // Decode write side effects: flush start and turn-off clears.
    always_comb begin
        start_o     = ctrl_wr && wdata_i[CB_FLUSH] && !busy_i
                      && !off_q && !wdata_i[CB_OFF];
        off_clr_v_o = ctrl_wr && wdata_i[CB_OFF] && wdata_i[CB_OCLR_V];
        off_clr_d_o = ctrl_wr && wdata_i[CB_OFF] && wdata_i[CB_OCLR_D];
    end

    // Read mux for the selected register.
    always_comb begin
        rdata_o = '0;
        if (addr_i == REG_CTRL) begin
            rdata_o[CB_FLUSH]  = busy_i;
            rdata_o[CB_OFF]    = off_q;
            rdata_o[CB_SET_V]  = set_v_q;
            rdata_o[CB_SET_D]  = set_d_q;
            rdata_o[CB_FCLR_V] = fclr_v_q;
            rdata_o[CB_FCLR_D] = fclr_d_q;
            rdata_o[CB_OCLR_V] = oclr_v_q;
            rdata_o[CB_OCLR_D] = oclr_d_q;
        end else begin
            rdata_o[IDX_W-1:0] = count_q;
        end
    end

    assign count_o  = count_q;
    assign set_v_o  = set_v_q;
    assign set_d_o  = set_d_q;
    assign fclr_v_o = fclr_v_q;
    assign fclr_d_o = fclr_d_q;

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_i) |-> $stable(count_o)); // R11

endmodule

// File: rtl/cmaint_walker.sv
// Module: flush sequencer. It visits lines 0..last in order and requests a
// write-back for each valid and dirty line, stalling until acknowledged.
// Assumes the line count does not change while busy (held off by the
// register file). The done pulse is combinational, so bulk clears land
// on the same edge that drops busy.
module cmaint_walker #(
    parameter int LINES = 128,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] last_i,
    input  logic [LINES-1:0] valid_i,
    input  logic [LINES-1:0] dirty_i,
    input  logic             wb_ack_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             wb_req_o,
    output logic [IDX_W-1:0] wb_line_o
);
    import cmaint_pkg::*;

    localparam logic [IDX_W-1:0] IDX_ONE = {{(IDX_W-1){1'b0}}, 1'b1};

    walk_state_t      state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             needs_wb, at_last;

    assign needs_wb = valid_i[idx_q] && dirty_i[idx_q];
    assign at_last  = (idx_q == last_i);

    // Next-state logic of the walk.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        done_o  = 1'b0;
        case (state_q)
            WK_IDLE: begin
                if (start_i) begin
                    state_d = WK_SCAN;
                    idx_d   = '0;
                end
            end
            WK_SCAN: begin
                if (last_i == '0) begin
                    done_o = 1'b1;
                end else if (needs_wb) begin
                    state_d = WK_WAIT;
                end else if (at_last) begin
                    done_o = 1'b1;
                end else begin
                    idx_d = idx_q + IDX_ONE;
                end
            end
            WK_WAIT: begin
                if (wb_ack_i) begin
                    if (at_last) begin
                        done_o = 1'b1;
                    end else begin
                        idx_d   = idx_q + IDX_ONE;
                        state_d = WK_SCAN;
                    end
                end
            end
            default: state_d = WK_IDLE;
        endcase
        if (done_o) begin
            state_d = WK_IDLE;
        end
    end

    // State and line index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WK_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    assign busy_o    = (state_q != WK_IDLE);
    assign wb_req_o  = (state_q == WK_WAIT);
    assign wb_line_o = idx_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req_o && !wb_ack_i) |=> (wb_req_o && $stable(wb_line_o))); // R7

    AST_REQ_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_req_o) |-> $past(valid_i[wb_line_o] && dirty_i[wb_line_o])); // R6

    AST_ORDER_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (wb_line_o >= $past(wb_line_o))); // R3

    AST_REQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req_o |-> (wb_line_o <= last_i)); // R3

endmodule

// File: rtl/cache_maint_ctrl.sv
// Module: top of the cache maintenance controller. It joins the register
// file, the flush walker and the two state bit arrays.
// Assumes the cache datapath marks lines through the mark ports and the
// write-back path answers each request with a one-cycle acknowledge.
module cache_maint_ctrl #(
    parameter int LINES = cmaint_pkg::NUM_LINES,
    parameter int IDX_W = cmaint_pkg::LINE_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             dirty_en,
    input  logic [IDX_W-1:0] dirty_idx,
    input  logic [IDX_W-1:0] probe_idx,
    output logic             probe_valid,
    output logic             probe_dirty,
    output logic             wb_req,
    output logic [IDX_W-1:0] wb_line,
    input  logic             wb_ack
);

    localparam int KINDS = 2;  // 0: valid array, 1: dirty array

    logic [IDX_W-1:0] count;
    logic             start, busy, done;
    logic             set_v, set_d, fclr_v, fclr_d, off_clr_v, off_clr_d;

    logic [KINDS-1:0]            k_mark, k_clr, k_set;
    logic [KINDS-1:0][IDX_W-1:0] k_idx;
    logic [KINDS-1:0][LINES-1:0] k_bits;

    cmaint_regs #(.IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .rdata_o    (reg_rdata),
        .busy_i     (busy),
        .count_o    (count),
        .start_o    (start),
        .set_v_o    (set_v),
        .set_d_o    (set_d),
        .fclr_v_o   (fclr_v),
        .fclr_d_o   (fclr_d),
        .off_clr_v_o(off_clr_v),
        .off_clr_d_o(off_clr_d)
    );

    cmaint_walker #(.LINES(LINES), .IDX_W(IDX_W)) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .last_i   (count),
        .valid_i  (k_bits[0]),
        .dirty_i  (k_bits[1]),
        .wb_ack_i (wb_ack),
        .busy_o   (busy),
        .done_o   (done),
        .wb_req_o (wb_req),
        .wb_line_o(wb_line)
    );

    // Route mark, clear and force controls to each array kind.
    always_comb begin
        k_mark = {dirty_en, fill_en};
        k_idx  = {dirty_idx, fill_idx};
        k_set  = {set_d, set_v};
        k_clr  = {(done && fclr_d) || off_clr_d, (done && fclr_v) || off_clr_v};
    end

    for (genvar g = 0; g < KINDS; g++) begin : g_arr
        cmaint_line_bits #(.LINES(LINES), .IDX_W(IDX_W)) u_bits (
            .clk       (clk),
            .rst_n     (rst_n),
            .mark_en_i (k_mark[g]),
            .mark_idx_i(k_idx[g]),
            .clr_all_i (k_clr[g]),
            .set_all_i (k_set[g]),
            .bits_o    (k_bits[g])
        );
    end

    assign probe_valid = k_bits[0][probe_idx];
    assign probe_dirty = k_bits[1][probe_idx];

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R4

    AST_OFF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr && reg_wdata[1] && !busy) |=> !busy); // R5

endmodule

// File: tb/cache_maint_ctrl_bench.sv
module cache_maint_ctrl_bench;

    localparam int N = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       fill_en = 1'b0;
    logic [6:0] fill_idx = '0;
    logic       dirty_en = 1'b0;
    logic [6:0] dirty_idx = '0;
    logic [6:0] probe_idx = '0;
    logic       probe_valid, probe_dirty;
    logic       wb_req;
    logic [6:0] wb_line;
    logic       wb_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    int ack_gap = 0;
    int ack_cnt = 0;
    int wb_log[$];
    logic req_prev = 1'b0;

    // reference model state
    int         m_st = 0;       // 0 idle, 1 scanning, 2 waiting
    int         m_idx = 0;
    int         m_cnt = 127;
    logic [N-1:0] m_v = '0, m_d = '0;
    logic m_off = 0, m_sv = 0, m_sd = 0, m_fv = 1, m_fd = 1, m_ov = 1, m_od = 1;

    always #10 clk = ~clk;

    cache_maint_ctrl u_cache_maint_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fill_en(fill_en),
        .fill_idx(fill_idx), .dirty_en(dirty_en), .dirty_idx(dirty_idx),
        .probe_idx(probe_idx), .probe_valid(probe_valid), .probe_dirty(probe_dirty),
        .wb_req(wb_req), .wb_line(wb_line), .wb_ack(wb_ack)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, stepped on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_idx = 0; m_cnt = 127; m_v = '0; m_d = '0;
            m_off = 0; m_sv = 0; m_sd = 0; m_fv = 1; m_fd = 1; m_ov = 1; m_od = 1;
        end else begin
            bit busy0, fin, cv, cd, sv0, sd0;
            logic [N-1:0] nv, nd;
            busy0 = (m_st != 0);
            sv0 = m_sv; sd0 = m_sd;
            fin = 0;
            if (m_st == 1) begin
                if (m_cnt == 0) fin = 1;
                else if (m_v[m_idx] && m_d[m_idx]) m_st = 2;
                else if (m_idx == m_cnt) fin = 1;
                else m_idx++;
            end else if (m_st == 2 && wb_ack) begin
                if (m_idx == m_cnt) fin = 1;
                else begin m_idx++; m_st = 1; end
            end
            if (fin) m_st = 0;
            cv = fin && m_fv;
            cd = fin && m_fd;
            if (reg_wr && reg_addr == 1'b0 && !busy0) m_cnt = int'(reg_wdata[6:0]);
            if (reg_wr && reg_addr == 1'b1) begin
                if (reg_wdata[1] && reg_wdata[6]) cv = 1;
                if (reg_wdata[1] && reg_wdata[7]) cd = 1;
                if (reg_wdata[0] && !busy0 && !m_off && !reg_wdata[1]) begin
                    m_st = 1; m_idx = 0;
                end
                m_off = reg_wdata[1]; m_sv = reg_wdata[2]; m_sd = reg_wdata[3];
                m_fv = reg_wdata[4]; m_fd = reg_wdata[5];
                m_ov = reg_wdata[6]; m_od = reg_wdata[7];
            end
            nv = m_v; nd = m_d;
            if (sv0) nv = '1;
            else if (cv) nv = '0;
            else if (fill_en) nv[fill_idx] = 1'b1;
            if (sd0) nd = '1;
            else if (cd) nd = '0;
            else if (dirty_en) nd[dirty_idx] = 1'b1;
            m_v = nv; m_d = nd;
        end
    end

    // Per-cycle comparison of all outputs against the model.
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            logic [7:0] er;
            er = reg_addr ? {m_od, m_ov, m_fd, m_fv, m_sd, m_sv, m_off, (m_st != 0)}
                          : {1'b0, 7'(m_cnt)};
            chk(reg_addr ? "R4 ctrl read" : "R11 count read", int'(reg_rdata), int'(er));
            chk("R7 wb_req", int'(wb_req), int'(m_st == 2));
            if (wb_req) chk("R6 wb_line", int'(wb_line), m_idx);
            chk("R8 probe_valid", int'(probe_valid), int'(m_v[probe_idx]));
            chk("R9 probe_dirty", int'(probe_dirty), int'(m_d[probe_idx]));
            if (wb_req && !req_prev) wb_log.push_back(int'(wb_line));
            req_prev = wb_req;
        end
    end

    // Write-back responder with a programmable delay.
    always @(negedge clk) begin
        if (wb_ack) begin
            wb_ack = 1'b0;
        end else if (wb_req) begin
            if (ack_cnt >= ack_gap) begin
                wb_ack = 1'b1;
                ack_cnt = 0;
            end else begin
                ack_cnt++;
            end
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic mark(input int idx, input bit v, input bit d);
        @(negedge clk);
        fill_en = v; fill_idx = 7'(idx); dirty_en = d; dirty_idx = 7'(idx);
        @(negedge clk);
        fill_en = 1'b0; dirty_en = 1'b0;
    endtask

    task automatic wait_idle();
        reg_addr = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            #2;
            if (!reg_rdata[0]) return;
        end
        chk("R4 flush never ended", 1, 0);
    endtask

    task automatic count_bits(output int nv, output int nd);
        nv = 0; nd = 0;
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            probe_idx = 7'(i);
            #2;
            nv += int'(probe_valid);
            nd += int'(probe_dirty);
        end
    endtask

    task automatic probe_chk(input int idx, input int ev, input int ed);
        @(negedge clk);
        probe_idx = 7'(idx);
        #2;
        chk("R2 mark valid", int'(probe_valid), ev);
        chk("R2 mark dirty", int'(probe_dirty), ed);
    endtask

    initial begin
        int nv, nd;
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int nv, nd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        @(negedge clk); reg_addr = 1'b0; #2;
        chk("R1 count reset", int'(reg_rdata), 8'h7F);
        @(negedge clk); reg_addr = 1'b1; #2;
        chk("R1 ctrl reset", int'(reg_rdata), 8'hF0);
        chk("R1 no request", int'(wb_req), 0);
        count_bits(nv, nd);
        chk("R1 valid empty", nv, 0);
        chk("R1 dirty empty", nd, 0);

        // R2: single-line marking
        mark(5, 1, 1); mark(6, 1, 0); mark(7, 0, 1);
        mark(2, 1, 1); mark(9, 1, 1); mark(10, 1, 1);
        probe_chk(5, 1, 1); probe_chk(6, 1, 0); probe_chk(7, 0, 1);

        // R3 R6 R7 R11: flush lines 0..9 with a slow acknowledge
        ack_gap = 4;
        wr(1'b0, 8'd9);
        wb_log.delete();
        wr(1'b1, 8'hF1);
        wr(1'b0, 8'd3);          // R11: ignored while busy
        wait_idle();
        chk("R6 request count", wb_log.size(), 3);
        if (wb_log.size() == 3) begin
            chk("R3 order first", wb_log[0], 2);
            chk("R3 order second", wb_log[1], 5);
            chk("R3 last checked line", wb_log[2], 9);
        end
        @(negedge clk); reg_addr = 1'b0; #2;
        chk("R11 count kept", int'(reg_rdata), 9);
        count_bits(nv, nd);
        chk("R8 valid cleared", nv, 0);
        chk("R8 dirty cleared", nd, 0);

        // R8: flush with clear enables off keeps state
        ack_gap = 1;
        mark(1, 1, 1); mark(3, 1, 1);
        wr(1'b1, 8'hC1);
        wait_idle();
        count_bits(nv, nd);
        chk("R8 valid kept", nv, 2);
        chk("R8 dirty kept", nd, 2);

        // R3: zero count ends after one busy cycle with no request
        wr(1'b0, 8'd0);
        wb_log.delete();
        wr(1'b1, 8'hC1);
        reg_addr = 1'b1; #2;
        chk("R4 busy after start", int'(reg_rdata[0]), 1);
        @(negedge clk); #2;
        chk("R3 zero count done", int'(reg_rdata[0]), 0);
        chk("R3 zero count no request", wb_log.size(), 0);

        // R9: turn-off clears per enables
        wr(1'b1, 8'hC2);
        count_bits(nv, nd);
        chk("R9 off clears valid", nv, 0);
        chk("R9 off clears dirty", nd, 0);
        mark(1, 1, 1); mark(3, 1, 1);
        wr(1'b1, 8'h42);
        count_bits(nv, nd);
        chk("R9 valid only cleared", nv, 0);
        chk("R9 dirty untouched", nd, 2);

        // R5: flush ignored while off or being turned off
        wr(1'b1, 8'h43);
        reg_addr = 1'b1; #2;
        chk("R5 off already set", int'(reg_rdata[0]), 0);
        wr(1'b1, 8'h40);
        wr(1'b1, 8'h43);
        reg_addr = 1'b1; #2;
        chk("R5 off written with flush", int'(reg_rdata[0]), 0);

        // R10: force-set-all beats a turn-off clear
        wr(1'b1, 8'h44);
        count_bits(nv, nd);
        chk("R10 all valid", nv, N);
        wr(1'b1, 8'hCE);
        count_bits(nv, nd);
        chk("R10 valid forced over clear", nv, N);
        chk("R10 dirty forced over clear", nd, N);

        // R3 R6: full-length flush of an all-dirty cache
        ack_gap = 0;
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h7F);
        wb_log.delete();
        wr(1'b1, 8'h31);
        wait_idle();
        chk("R6 full flush requests", wb_log.size(), N);
        if (wb_log.size() == N) begin
            chk("R3 full first line", wb_log[0], 0);
            chk("R3 full last line", wb_log[N-1], N - 1);
        end
        count_bits(nv, nd);
        chk("R8 full flush valid", nv, 0);
        chk("R8 full flush dirty", nd, 0);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule